// File: doc/BRIEF.md
# Bus Clock Prescaler Search Engine

This block chooses the best setting of a two-stage bus clock prescaler. The first stage divides an input clock by ten times (M+1), with M a 4-bit value. The second stage halves the result N times, with N a 3-bit value. Given the input clock frequency and a wanted bus rate, both as 32-bit integers, the engine scores all 128 (M, N) pairs. It returns the pair whose rate lies closest to the target, together with the remaining absolute error.

The engine runs in two phases. In the first phase, a serial restoring divider works out the sixteen first-stage quotients, one for each M, and keeps them in a small table. In the second phase, the engine reads one table entry and shifts it each cycle, scoring one candidate per cycle. A caller pulses `start` while the engine is idle, waits for `done`, and then reads the result, which stays put until the next accepted start.

Top module: `bus_rate_search`

## Requirements
- R1: After reset, busy and done are 0, mOut and nOut are 0 and errOut is 0xFFFFFFFF.
- R2: The candidate rate for a pair is floor(floor(F / (10*(M+1))) / 2^N), with M in 0..15 and N in 0..7. Its error is |T - rate|, where F is freqIn and T is targetIn, both captured at start. At done, mOut, nOut and errOut give the pair with the minimum error and that error.
- R3: Candidates are scored with N as the outer loop from 0 up and M as the inner loop from 0 up. A candidate replaces the held best only if its error is strictly smaller, so among equal errors the earliest pair in this order is reported.
- R4: Each accepted start resets the held best to M=0, N=0 and error 0xFFFFFFFF. If no candidate beats that error, the result is M=0, N=0, errOut=0xFFFFFFFF.
- R5: After start is sampled high while idle, busy is high from the next cycle until done. done is high for exactly one cycle, on the cycle busy goes low. done becomes visible 672 clock edges after the edge that sampled start (16*(32+2) divide cycles plus 128 scoring cycles).
- R6: A start pulse that arrives while busy is ignored: it does not change the result, the timing, or the number of done pulses.
- R7: From done until the next accepted start, mOut, nOut and errOut stay constant.
- R8: During a run, errOut never increases from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a search; sampled only while idle |
| freqIn | input | 32 | Input clock frequency, integer |
| targetIn | input | 32 | Wanted bus rate, integer |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| mOut | output | 4 | Best first-stage multiplier index |
| nOut | output | 3 | Best second-stage exponent |
| errOut | output | 32 | Absolute error of the best pair |

## Verification
The bench targets tie cases, such as a tiny clock with target zero, where many pairs give rate zero. A design that uses less-or-equal, or scans in the wrong order, would report a later pair than the expected N=0, M=10. An input clock of zero with a target of all ones gives every candidate exactly the starting error. This checks that the held best is never replaced and that it was reinitialised at start, rather than carried over from the previous run. A start injected mid-run with other operands must leave the result and the 672-cycle latency unchanged; a design that restarts or recaptures would shift both. Exact-match and full-range operands check the divider's quotient bits and the shift by N.

// File: rtl/bus_rate_search_pkg.sv
package bus_rate_search_pkg;
  localparam int FREQ_W = 32;
  localparam int M_W    = 4;
  localparam int N_W    = 3;
  localparam int SCALE  = 10;
  localparam int M_CNT  = 1 << M_W;
  localparam int N_CNT  = 1 << N_W;
  localparam int DIV_W  = $clog2(SCALE * M_CNT + 1);
  localparam int BIT_W  = $clog2(FREQ_W);

  typedef struct packed {
    logic           capture;
    logic           divLoad;
    logic           divStep;
    logic           divWrite;
    logic           evalEn;
    logic [M_W-1:0] mSel;
    logic [N_W-1:0] nSel;
  } srch_ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_STEP, ST_WRITE, ST_SCAN
  } srch_state_t;
endpackage

// File: rtl/bus_rate_search_ctrl.sv
module bus_rate_search_ctrl
  import bus_rate_search_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output srch_ctl_t ctl,
  output logic      busy,
  output logic      done
);
  localparam logic [M_W-1:0]   M_LAST   = M_W'(M_CNT - 1);
  localparam logic [N_W-1:0]   N_LAST   = N_W'(N_CNT - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FREQ_W - 1);

  srch_state_t      state;
  logic [M_W-1:0]   mCnt;
  logic [N_W-1:0]   nCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             scanLast;

  assign scanLast = (mCnt == M_LAST) && (nCnt == N_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      mCnt   <= '0;
      nCnt   <= '0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mCnt  <= '0;
            nCnt  <= '0;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          bitCnt <= '0;
          state  <= ST_STEP;
        end
        ST_STEP: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == BIT_LAST) state <= ST_WRITE;
        end
        ST_WRITE: begin
          if (mCnt == M_LAST) begin
            mCnt  <= '0;
            nCnt  <= '0;
            state <= ST_SCAN;
          end else begin
            mCnt  <= mCnt + 1'b1;
            state <= ST_LOAD;
          end
        end
        ST_SCAN: begin
          if (scanLast) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (mCnt == M_LAST) begin
            mCnt <= '0;
            nCnt <= nCnt + 1'b1;
          end else begin
            mCnt <= mCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.capture  = (state == ST_IDLE) && start;
    ctl.divLoad  = (state == ST_LOAD);
    ctl.divStep  = (state == ST_STEP);
    ctl.divWrite = (state == ST_WRITE);
    ctl.evalEn   = (state == ST_SCAN);
    ctl.mSel     = mCnt;
    ctl.nSel     = nCnt;
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/bus_rate_search_dp.sv
module bus_rate_search_dp
  import bus_rate_search_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  srch_ctl_t         ctl,
  input  logic [FREQ_W-1:0] freqIn,
  input  logic [FREQ_W-1:0] targetIn,
  output logic [M_W-1:0]    bestM,
  output logic [N_W-1:0]    bestN,
  output logic [FREQ_W-1:0] bestErr
);
  logic [FREQ_W-1:0] clkReg;
  logic [FREQ_W-1:0] tgtReg;
  logic [FREQ_W-1:0] work;
  logic [DIV_W-1:0]  rem;
  logic [DIV_W-1:0]  divisor;
  logic [DIV_W:0]    trial;
  logic              trialFits;
  logic [FREQ_W-1:0] qTable [M_CNT];
  logic [FREQ_W-1:0] cand;
  logic [FREQ_W-1:0] candErr;

  // divisor for the selected multiplier index
  assign divisor   = DIV_W'(SCALE) * (DIV_W'(ctl.mSel) + DIV_W'(1));
  assign trial     = {rem, work[FREQ_W-1]};
  assign trialFits = (trial >= {1'b0, divisor});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkReg <= '0;
      tgtReg <= '0;
      work   <= '0;
      rem    <= '0;
    end else begin
      if (ctl.capture) begin
        clkReg <= freqIn;
        tgtReg <= targetIn;
      end
      if (ctl.divLoad) begin
        work <= clkReg;
        rem  <= '0;
      end else if (ctl.divStep) begin
        work <= {work[FREQ_W-2:0], trialFits};
        rem  <= trialFits ? DIV_W'(trial - {1'b0, divisor}) : trial[DIV_W-1:0];
      end
    end
  end

  // one quotient register per multiplier index
  for (genvar gi = 0; gi < M_CNT; gi++) begin : g_qtab
    always_ff @(posedge clk) begin
      if (!rstN) qTable[gi] <= '0;
      else if (ctl.divWrite && (ctl.mSel == M_W'(gi))) qTable[gi] <= work;
    end
  end

  assign cand    = qTable[ctl.mSel] >> ctl.nSel;
  assign candErr = (tgtReg >= cand) ? (tgtReg - cand) : (cand - tgtReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestM   <= '0;
      bestN   <= '0;
      bestErr <= '1;
    end else if (ctl.capture) begin
      bestM   <= '0;
      bestN   <= '0;
      bestErr <= '1;
    end else if (ctl.evalEn && (candErr < bestErr)) begin
      bestM   <= ctl.mSel;
      bestN   <= ctl.nSel;
      bestErr <= candErr;
    end
  end
endmodule

// File: rtl/bus_rate_search.sv
module bus_rate_search
  import bus_rate_search_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FREQ_W-1:0] freqIn,
  input  logic [FREQ_W-1:0] targetIn,
  output logic              busy,
  output logic              done,
  output logic [M_W-1:0]    mOut,
  output logic [N_W-1:0]    nOut,
  output logic [FREQ_W-1:0] errOut
);
  srch_ctl_t ctl;

  bus_rate_search_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  bus_rate_search_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .freqIn   (freqIn),
    .targetIn (targetIn),
    .bestM    (mOut),
    .bestN    (nOut),
    .bestErr  (errOut)
  );
endmodule

// File: rtl/bus_rate_search_chk.sv
module bus_rate_search_chk
  import bus_rate_search_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [M_W-1:0]    mOut,
  input logic [N_W-1:0]    nOut,
  input logic [FREQ_W-1:0] errOut
);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(mOut) && $stable(nOut) && $stable(errOut)));
  // R8
  err_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (errOut <= $past(errOut)));
endmodule

bind bus_rate_search bus_rate_search_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .mOut   (mOut),
  .nOut   (nOut),
  .errOut (errOut)
);

// File: tb/bus_rate_search_tb_top.sv
module bus_rate_search_tb_top;
  localparam int LAT = 16 * (32 + 2) + 16 * 8;

  typedef struct {
    logic [3:0]  m;
    logic [2:0]  n;
    logic [31:0] e;
    int          t0;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] freqIn = '0;
  logic [31:0] targetIn = '0;
  logic        busy, done;
  logic [3:0]  mOut;
  logic [2:0]  nOut;
  logic [31:0] errOut;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   pushes = 0;
  int   dones = 0;
  exp_t sbq[$];
  exp_t lastExp;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_rate_search dut_i (
    .clk(clk), .rstN(rstN), .start(start), .freqIn(freqIn), .targetIn(targetIn),
    .busy(busy), .done(done), .mOut(mOut), .nOut(nOut), .errOut(errOut)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // reference search built from the stated rules (R2, R3, R4)
  function automatic exp_t refSearch(input logic [31:0] f, input logic [31:0] t);
    exp_t r;
    r.m = '0; r.n = '0; r.e = '1; r.t0 = 0;
    for (int n = 0; n < 8; n++) begin
      for (int m = 0; m < 16; m++) begin
        logic [31:0] c, e;
        c = (f / 32'(10 * (m + 1))) >> n;
        e = (t >= c) ? t - c : c - t;
        if (e < r.e) begin
          r.e = e; r.m = 4'(m); r.n = 3'(n);
        end
      end
    end
    return r;
  endfunction

  task automatic runReq(input logic [31:0] f, input logic [31:0] t);
    exp_t x;
    @(negedge clk);
    while (busy) @(negedge clk);
    x = refSearch(f, t);
    x.t0 = cyc;
    sbq.push_back(x);
    pushes++;
    freqIn = f; targetIn = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDrain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  // monitor: compare each done against the oldest expectation
  always @(negedge clk) begin
    if (rstN && done) begin
      dones++;
      if (sbq.size() == 0) begin
        chk(1'b0, "R6 unexpected done", 1, 0);
      end else begin
        exp_t x;
        x = sbq.pop_front();
        lastExp = x;
        chk(mOut == x.m, "R2/R3 mOut", longint'(mOut), longint'(x.m));
        chk(nOut == x.n, "R2/R3 nOut", longint'(nOut), longint'(x.n));
        chk(errOut == x.e, "R2/R4 errOut", longint'(errOut), longint'(x.e));
        // done visible on the negedge after edge start+LAT; counter already advanced by LAT+1
        chk((cyc - x.t0) == LAT + 1, "R5 latency", longint'(cyc - x.t0), longint'(LAT + 1));
        chk(!busy, "R5 busy low at done", longint'(busy), 0);
      end
    end
  end

  task automatic checkHold();
    repeat (25) @(negedge clk);
    chk(!busy && !done, "R7 idle", longint'({busy, done}), 0);
    chk(mOut == lastExp.m && nOut == lastExp.n && errOut == lastExp.e, "R7 hold",
        longint'({mOut, nOut, errOut}), longint'({lastExp.m, lastExp.n, lastExp.e}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 busy/done", longint'({busy, done}), 0);
    chk(mOut == 0 && nOut == 0, "R1 m/n", longint'({mOut, nOut}), 0);
    chk(errOut == 32'hFFFF_FFFF, "R1 errOut", longint'(errOut), 64'hFFFF_FFFF);
    rstN = 1'b1;

    // R2 typical operands
    runReq(32'd100_000_000, 32'd100_000);
    @(negedge clk);
    chk(busy, "R5 busy after start", longint'(busy), 1);
    waitDrain();
    checkHold();

    runReq(32'd25_000_000, 32'd400_000);
    // R6 start with other operands while busy
    repeat (100) @(negedge clk);
    freqIn = 32'd7; targetIn = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDrain();
    checkHold();

    // R2 exact match possible
    runReq(32'd48_000_000, 32'd100_000);
    waitDrain();
    // R3 tie: many pairs give rate 0 for target 0
    runReq(32'd100, 32'd0);
    waitDrain();
    // R4 no candidate beats the starting error
    runReq(32'd0, 32'hFFFF_FFFF);
    waitDrain();
    checkHold();
    // R2 full-range operands
    runReq(32'hFFFF_FFFF, 32'd1);
    waitDrain();
    runReq(32'd133_333_333, 32'd3_400_000);
    waitDrain();

    repeat (10) @(negedge clk);
    // R6 no extra done from the ignored start
    chk(dones == pushes, "R6 done count", longint'(dones), longint'(pushes));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule